// File: doc/BRIEF.md
# Packed Register Access Command Executor

This block is the controller-side engine behind a command mailbox. Once a command is started, it takes the opcode, a command id, a byte count and a 16-byte write buffer. It decodes the packed list of register entries in that buffer. It then performs the requested writes, reads or masked read-modify-writes on a target register file. The target has 16-bit addresses and 8-bit data and is reached through a request/acknowledge port.

Read results are placed in a read buffer that holds its contents between commands. When the last access completes, the block pulses `done_o` together with an error flag and an error code. A malformed command is rejected before any target access is made. Buffer byte k is always bits [8k+7:8k] of the flat buffer ports.

Top module: `regacc_exec`

## Requirements
- R1: After reset, `done_o`, `err_o`, `busy_o` and `tgt_req_o` are 0, `err_code_o` is 0 and every read-buffer byte is 0.
- R2: A command is accepted on `start_i` only while `busy_o` is 0. A `start_i` pulse while busy has no effect on the running command or on its result.
- R3: Command id 0 writes. Entry n uses write-buffer bytes 3n (address low), 3n+1 (address high) and 3n+2 (data). One target write is issued per entry, in entry order.
- R4: Command id 1 reads. Entries use the same 3-byte layout and their data byte is ignored. The byte read for entry n is stored in read-buffer byte 2+3n.
- R5: Command id 2 is a masked update. Entry n uses bytes 4n (address low), 4n+1 (address high), 4n+2 (value) and 4n+3 (mask). Each entry issues a read and then a write of the same address with data (old AND NOT mask) OR (value AND mask).
- R6: The size must be nonzero, a multiple of the entry length (3, or 4 for id 2), at most 16, and must imply at most 5 entries. Otherwise the command ends with error code 3.
- R7: An opcode other than 0xFF ends the command with error code 1. Otherwise, a command id above 2 ends it with error code 2. A rejected command makes no target access.
- R8: Only one target access is outstanding at a time. While `tgt_req_o` waits for `tgt_ack_i`, the address, direction and write data stay stable.
- R9: `done_o` is a one-cycle pulse. It comes in the cycle after the last acknowledge, or in the cycle after acceptance for a rejected command. `err_o`/`err_code_o` are valid with it and are 0 on success.
- R10: Read-buffer bytes not written by the current command keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new command |
| opcode_i | input | 8 | Message opcode (0xFF expected) |
| cmd_id_i | input | 4 | 0 write, 1 read, 2 masked update |
| size_i | input | 8 | Payload size in bytes |
| wbuf_i | input | 128 | Write buffer, byte k at [8k+7:8k] |
| tgt_req_o | output | 1 | Target access request |
| tgt_we_o | output | 1 | Target access is a write |
| tgt_addr_o | output | 16 | Target register address |
| tgt_wdata_o | output | 8 | Target write data |
| tgt_ack_i | input | 1 | Target acknowledge |
| tgt_rdata_i | input | 8 | Target read data, valid with acknowledge |
| rbuf_o | output | 128 | Read buffer, byte k at [8k+7:8k] |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 1 | Command rejected |
| err_code_o | output | 8 | 0 ok, 1 opcode, 2 command id, 3 size |

## Verification
A zero-wait target can acknowledge in the first cycle of a request. In that one cycle the block must capture read data into the read buffer (or form the merged update value) and also advance to the next entry or its write phase. The bench provokes this by running every command id and entry count with target latencies 0, 1 and 2. It judges the result from the ordered access log against an arithmetic model of the register file, the full read buffer, and the cycle of `done_o` relative to the final acknowledge. A stray start pulse injected mid-command checks that acceptance cannot coincide with a running command.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [7:0] OP_PWR = 8'hFF;
  localparam int unsigned CMD_WR  = 0;
  localparam int unsigned CMD_RD  = 1;
  localparam int unsigned CMD_RMW = 2;
  localparam logic [7:0] ERR_NONE = 8'd0;
  localparam logic [7:0] ERR_OP   = 8'd1;
  localparam logic [7:0] ERR_ID   = 8'd2;
  localparam logic [7:0] ERR_SIZE = 8'd3;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_WB, S_FIN} state_e;
endpackage

// File: rtl/regacc_decode.sv
module regacc_decode import regacc_pkg::*; #(
  parameter int unsigned ID_W      = 4,
  parameter int unsigned SIZE_W    = 8,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned MAX_ENT   = 5,
  localparam int unsigned CW       = $clog2(MAX_ENT + 1)
) (
  input  logic [7:0]        opcode_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [7:0]        code_o,
  output logic [CW-1:0]     count_o
);
  logic              rmw;
  logic [SIZE_W-1:0] q, r;

  assign rmw = (cmd_id_i == ID_W'(CMD_RMW));

  always_comb begin
    if (rmw) begin
      q = size_i >> 2;
      r = size_i & SIZE_W'(3);
    end else begin
      q = size_i / SIZE_W'(3);
      r = size_i % SIZE_W'(3);
    end
  end

  assign count_o = q[CW-1:0];

  always_comb begin
    if (opcode_i != OP_PWR)                     code_o = ERR_OP;
    else if (cmd_id_i > ID_W'(CMD_RMW))         code_o = ERR_ID;
    else if (size_i == '0 || r != '0 ||
             q > SIZE_W'(MAX_ENT) ||
             size_i > SIZE_W'(BUF_BYTES))       code_o = ERR_SIZE;
    else                                        code_o = ERR_NONE;
  end
endmodule

// File: rtl/regacc_entry_sel.sv
module regacc_entry_sel import regacc_pkg::*; #(
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CW        = 3,
  localparam int unsigned OW       = CW + 2,
  localparam int unsigned NP       = 2 ** OW
) (
  input  logic [BUF_BYTES*8-1:0] wbuf_i,
  input  logic [CW-1:0]          idx_i,
  input  logic                   rmw_i,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [DATA_W-1:0]      val_o,
  output logic [DATA_W-1:0]      mask_o
);
  logic [7:0]    byte_a [NP];
  logic [OW-1:0] base;

  for (genvar k = 0; k < NP; k++) begin : g_pad
    if (k < BUF_BYTES) begin : g_in
      assign byte_a[k] = wbuf_i[8*k +: 8];
    end else begin : g_zero
      assign byte_a[k] = 8'h00;
    end
  end

  assign base   = rmw_i ? {idx_i, 2'b00} : (OW'(idx_i) * OW'(3));
  assign addr_o = ADDR_W'({byte_a[base + OW'(1)], byte_a[base]});
  assign val_o  = byte_a[base + OW'(2)];
  assign mask_o = byte_a[base + OW'(3)];
endmodule

// File: rtl/regacc_rbuf.sv
module regacc_rbuf import regacc_pkg::*; #(
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned CW        = 3,
  localparam int unsigned OW       = CW + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [CW-1:0]          idx_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [BUF_BYTES*8-1:0] rbuf_o
);
  logic [OW-1:0] pos;
  assign pos = OW'(2) + OW'(idx_i) * OW'(3);

  for (genvar k = 0; k < BUF_BYTES; k++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        rbuf_o[8*k +: 8] <= 8'h00;
      else if (we_i && pos == OW'(k))     rbuf_o[8*k +: 8] <= data_i;
    end
  end
endmodule

// File: rtl/regacc_exec.sv
module regacc_exec import regacc_pkg::*; #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned SIZE_W    = 8,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned MAX_ENT   = 5,
  localparam int unsigned CW       = $clog2(MAX_ENT + 1),
  localparam int unsigned BUF_W    = BUF_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [BUF_W-1:0]  wbuf_i,
  output logic              tgt_req_o,
  output logic              tgt_we_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  input  logic              tgt_ack_i,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic [BUF_W-1:0]  rbuf_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        err_code_o
);
  state_e            st_q;
  logic [BUF_W-1:0]  wbuf_q;
  logic [ID_W-1:0]   id_q;
  logic [CW-1:0]     cnt_q, idx_q;
  logic [DATA_W-1:0] merged_q;
  logic              err_q;
  logic [7:0]        code_q;

  logic [7:0]        dec_code;
  logic [CW-1:0]     dec_cnt;
  logic [DATA_W-1:0] e_val, e_mask;
  logic              accept, is_rmw, is_rd, is_wr, last, rb_we;

  regacc_decode #(
    .ID_W(ID_W), .SIZE_W(SIZE_W), .BUF_BYTES(BUF_BYTES), .MAX_ENT(MAX_ENT)
  ) u_dec (
    .opcode_i(opcode_i), .cmd_id_i(cmd_id_i), .size_i(size_i),
    .code_o(dec_code), .count_o(dec_cnt)
  );

  regacc_entry_sel #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .CW(CW)
  ) u_sel (
    .wbuf_i(wbuf_q), .idx_i(idx_q), .rmw_i(is_rmw),
    .addr_o(tgt_addr_o), .val_o(e_val), .mask_o(e_mask)
  );

  regacc_rbuf #(
    .BUF_BYTES(BUF_BYTES), .CW(CW)
  ) u_rbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(rb_we), .idx_i(idx_q),
    .data_i(tgt_rdata_i), .rbuf_o(rbuf_o)
  );

  assign accept = (st_q == S_IDLE) && start_i;
  assign is_rmw = (id_q == ID_W'(CMD_RMW));
  assign is_rd  = (id_q == ID_W'(CMD_RD));
  assign is_wr  = (id_q == ID_W'(CMD_WR));
  assign last   = (idx_q == cnt_q - CW'(1));
  assign rb_we  = (st_q == S_ACC) && tgt_ack_i && is_rd;

  assign tgt_req_o   = (st_q == S_ACC) || (st_q == S_WB);
  assign tgt_we_o    = ((st_q == S_ACC) && is_wr) || (st_q == S_WB);
  assign tgt_wdata_o = (st_q == S_WB) ? merged_q : e_val;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_FIN);
  assign err_o       = err_q;
  assign err_code_o  = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      wbuf_q   <= '0;
      id_q     <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      merged_q <= '0;
      err_q    <= 1'b0;
      code_q   <= ERR_NONE;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          wbuf_q <= wbuf_i;
          id_q   <= cmd_id_i;
          cnt_q  <= dec_cnt;
          idx_q  <= '0;
          code_q <= dec_code;
          err_q  <= (dec_code != ERR_NONE);
          st_q   <= (dec_code != ERR_NONE) ? S_FIN : S_ACC;
        end
        S_ACC: if (tgt_ack_i) begin
          if (is_rmw) begin
            merged_q <= (tgt_rdata_i & ~e_mask) | (e_val & e_mask);
            st_q     <= S_WB;
          end else if (last) begin
            st_q <= S_FIN;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        S_WB: if (tgt_ack_i) begin
          if (last) st_q <= S_FIN;
          else begin
            idx_q <= idx_q + CW'(1);
            st_q  <= S_ACC;
          end
        end
        S_FIN: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regacc_exec_chk.sv
module regacc_exec_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned SIZE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [7:0]        opcode_i,
  input logic [ID_W-1:0]   cmd_id_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              tgt_req_o,
  input logic              tgt_we_o,
  input logic [ADDR_W-1:0] tgt_addr_o,
  input logic [7:0]        tgt_wdata_o,
  input logic              tgt_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [7:0]        err_code_o
);
  p_hold_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && !tgt_ack_i |=> tgt_req_o && $stable(tgt_addr_o) &&
                                $stable(tgt_we_o) && $stable(tgt_wdata_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> $past(tgt_ack_i));

  p_bad_op_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && opcode_i != 8'hFF |=>
      done_o && err_o && err_code_o == 8'd1 && !tgt_req_o);

  p_bad_id_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && opcode_i == 8'hFF && cmd_id_i > ID_W'(2) |=>
      done_o && err_o && err_code_o == 8'd2);

  p_zero_size_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && opcode_i == 8'hFF && cmd_id_i <= ID_W'(2) &&
    size_i == '0 |=> done_o && err_code_o == 8'd3);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tgt_req_o && !done_o);
endmodule

bind regacc_exec regacc_exec_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .SIZE_W(SIZE_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
  .cmd_id_i(cmd_id_i), .size_i(size_i), .tgt_req_o(tgt_req_o),
  .tgt_we_o(tgt_we_o), .tgt_addr_o(tgt_addr_o), .tgt_wdata_o(tgt_wdata_o),
  .tgt_ack_i(tgt_ack_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .err_code_o(err_code_o)
);

// File: tb/regacc_exec_tb_top.sv
module regacc_exec_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   opcode = 8'h00;
  logic [3:0]   cmd_id = 4'h0;
  logic [7:0]   size = 8'h00;
  logic [127:0] wbuf = '0;
  logic         req, we, ack = 1'b0, busy, done, err;
  logic [15:0]  addr;
  logic [7:0]   wdata, rdata = 8'h00, code;
  logic [127:0] rbuf;

  int checks = 0, fails = 0, cyc = 0;
  int lat = 0, wait_cnt = 0, last_ack_cyc = -1;
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  wb [16];
  logic [7:0]  exp_rb [16];
  logic [15:0] log_a [16];
  logic        log_w [16];
  logic [7:0]  log_d [16];
  int          log_n = 0;

  always #4 clk = ~clk;

  regacc_exec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .cmd_id_i(cmd_id), .size_i(size), .wbuf_i(wbuf), .tgt_req_o(req),
    .tgt_we_o(we), .tgt_addr_o(addr), .tgt_wdata_o(wdata), .tgt_ack_i(ack),
    .tgt_rdata_i(rdata), .rbuf_o(rbuf), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(code)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // target register file model
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
      wait_cnt = 0;
    end else if (req) begin
      if (wait_cnt >= lat) begin
        ack = 1'b1;
        wait_cnt = 0;
        if (we) mem[addr[7:0]] = wdata;
        else    rdata = mem[addr[7:0]];
        if (log_n < 16) begin
          log_a[log_n] = addr;
          log_w[log_n] = we;
          log_d[log_n] = we ? wdata : mem[addr[7:0]];
        end
        log_n++;
        last_ack_cyc = cyc;
      end else wait_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req_s, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req_s, what, act, expv);
    end
  endtask

  function automatic logic [127:0] pack_bytes();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = wb[k];
    return v;
  endfunction

  function automatic logic [127:0] pack_rb();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = exp_rb[k];
    return v;
  endfunction

  task automatic fill(input int id, input int n, input int seed);
    for (int k = 0; k < 16; k++) wb[k] = 8'(seed * 97 + k * 13 + 7);
    for (int e = 0; e < n; e++) begin
      int b;
      b = (id == 2) ? 4 * e : 3 * e;
      wb[b]     = 8'(seed * 11 + e * 29 + 3);
      wb[b + 1] = 8'(8'h40 + e + seed);
      wb[b + 2] = 8'(seed * 53 + e * 17 + 1);
      if (id == 2) wb[b + 3] = 8'h5A ^ 8'(e * 8'h33 + seed);
    end
  endtask

  // runs one command; exp_code 0 means a valid command whose effects are modeled
  task automatic run_cmd(input logic [7:0] op, input int id, input int sz, input int n,
                         input logic [7:0] exp_code, input bit inject);
    logic [15:0] ea [16];
    logic        ew [16];
    logic [7:0]  ed [16];
    int          en = 0, start_cyc, done_cyc = -1;
    bit          log_ok = 1'b1;
    if (exp_code == 8'd0) begin
      for (int e = 0; e < n; e++) begin
        logic [15:0] a;
        logic [7:0]  old, nv;
        int b;
        b = (id == 2) ? 4 * e : 3 * e;
        a = {wb[b + 1], wb[b]};
        old = exp_mem[a[7:0]];
        if (id == 0) begin
          ea[en] = a; ew[en] = 1; ed[en] = wb[b + 2]; en++;
          exp_mem[a[7:0]] = wb[b + 2];
        end else if (id == 1) begin
          ea[en] = a; ew[en] = 0; ed[en] = old; en++;
          exp_rb[2 + 3 * e] = old;
        end else begin
          nv = (old & ~wb[b + 3]) | (wb[b + 2] & wb[b + 3]);
          ea[en] = a; ew[en] = 0; ed[en] = old; en++;
          ea[en] = a; ew[en] = 1; ed[en] = nv;  en++;
          exp_mem[a[7:0]] = nv;
        end
      end
    end
    log_n = 0;
    last_ack_cyc = -1;
    @(negedge clk);
    start = 1'b1; opcode = op; cmd_id = 4'(id); size = 8'(sz); wbuf = pack_bytes();
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (done) begin done_cyc = cyc; break; end
      if (inject && t == 3) begin
        start = 1'b1; opcode = 8'h00; cmd_id = 4'd1; size = 8'd3; wbuf = '1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done_cyc >= 0, "R9", "done seen", done_cyc, 0);
    chk(err == (exp_code != 0), (exp_code == 3) ? "R6" : "R7", "err flag", err, exp_code != 0);
    chk(code == exp_code, (exp_code == 3) ? "R6" : "R7", "err code", code, exp_code);
    if (exp_code != 0)
      chk(done_cyc == start_cyc + 1, "R9", "reject done cycle", done_cyc, start_cyc + 1);
    else
      chk(done_cyc == last_ack_cyc + 1, "R9", "done after last ack", done_cyc, last_ack_cyc + 1);
    chk(log_n == en, (id == 2) ? "R5" : (id == 1) ? "R4" : "R3", "access count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++)
      if (log_a[i] != ea[i] || log_w[i] != ew[i] || log_d[i] != ed[i]) log_ok = 1'b0;
    chk(log_ok, (id == 2) ? "R5" : (id == 1) ? "R4" : "R3", "access log order/content", log_n, en);
    chk(rbuf == pack_rb(), "R10", "read buffer", rbuf[63:0], pack_rb() >> 0);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    for (int k = 0; k < 16; k++) exp_rb[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !err && !busy && !req && code == 8'h00, "R1", "reset outputs",
        {done, err, busy, req, code}, 0);
    chk(rbuf == '0, "R1", "reset read buffer", rbuf[63:0], 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 sweep over id, entry count and target latency
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int id = 0; id < 3; id++) begin
        for (int n = 1; n <= ((id == 2) ? 4 : 5); n++) begin
          fill(id, n, l * 16 + id * 5 + n);
          run_cmd(8'hFF, id, n * ((id == 2) ? 4 : 3), n, 8'd0, 1'b0);
        end
      end
    end

    // R10 short read leaves older result bytes untouched
    lat = 1;
    fill(1, 1, 77);
    run_cmd(8'hFF, 1, 3, 1, 8'd0, 1'b0);

    // R2 stray start while busy
    lat = 2;
    fill(0, 5, 88);
    run_cmd(8'hFF, 0, 15, 5, 8'd0, 1'b1);

    // R7 opcode and id rejection, with priority
    fill(0, 2, 3);
    run_cmd(8'hFE, 0, 6, 2, 8'd1, 1'b0);
    run_cmd(8'hFE, 7, 5, 2, 8'd1, 1'b0);
    run_cmd(8'hFF, 3, 6, 2, 8'd2, 1'b0);
    run_cmd(8'hFF, 15, 4, 2, 8'd2, 1'b0);
    // R6 size rules
    run_cmd(8'hFF, 0, 0, 0, 8'd3, 1'b0);
    run_cmd(8'hFF, 1, 7, 0, 8'd3, 1'b0);
    run_cmd(8'hFF, 0, 18, 0, 8'd3, 1'b0);
    run_cmd(8'hFF, 2, 6, 0, 8'd3, 1'b0);
    run_cmd(8'hFF, 2, 20, 0, 8'd3, 1'b0);
    // valid command after errors clears the error
    lat = 0;
    fill(2, 4, 99);
    run_cmd(8'hFF, 2, 16, 4, 8'd0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=<100000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule